// File: doc/BRIEF.md
# Deep Sleep Arming and Wake Controller

This block decides when a device may drop into its deepest power state and records why it came back out. Software first writes an arm bit, and the sleep command must then follow within one instruction cycle. If the command comes too late, the hardware disarms by itself. This tight pairing keeps a stray write from putting the device into deep sleep by accident.

While the device is in deep sleep, four events can wake it: a power-on reset event, the master clear line driven low, a time-out from the deep-sleep watchdog, and a change on the external interrupt pin to its configured level. The external pin only counts if its enable was set when deep sleep was entered. Every source that fires on the exit cycle sets its own sticky bit in the wake-source status. These bits stay until software arms again.

After a wake, the block blocks re-entry until software clears the release bit and a short guard of instruction cycles has passed. Every pin is a plain level or a one-cycle strobe. The block carries no data stream, so there is no valid/ready handshake.

Top module: `dsleep_ctrl`

## Requirements
- R1: Deep sleep (`dsleep_o`=1) starts on the clock edge after a `sleep_cmd_i` strobe that meets all of these conditions: the block is armed and awake, `reenter_ok_o`=1, and `arm_set_i` is not active in the same cycle. A command given in the same cycle as the arm write does not enter deep sleep, but it does arm the block.
- R2: The arm window closes on the first `icyc_tick_i` after the cycle in which the arm bit was set. If that tick comes without a sleep command, `armed_o` clears, and a later command has no effect until software arms again. A command that coincides with that tick still enters deep sleep.
- R3: When deep sleep exits, `dsleep_o` and `armed_o` both go low on the same edge. `armed_o` stays high for the whole deep-sleep period.
- R4: An `arm_set_i` strobe while awake sets `armed_o` and clears all four bits of `wake_src_o` on the next edge.
- R5: In deep sleep, the wake sources record their bits as follows: `por_i`=1 sets bit 0, `master_clr_n_i`=0 sets bit 1, and `wdog_tmo_i`=1 sets bit 3. Any of these ends deep sleep on the next edge. Sources that are active together all record their bits.
- R6: The external pin wakes the device (bit 2) only if `ext_int_en_i` was 1 in the entry cycle. Changing the enable during deep sleep has no effect.
- R7: `ext_int_i` passes through a two-flop synchronizer. A wake needs a transition to the level selected by `ext_int_pol_i` (1 = high, 0 = low). A pin change driven before clock edge k causes the exit at edge k+2, so `dsleep_o` is low after three edges. Two cases do not wake: a level that was already present at entry, and a transition toward the other level.
- R8: After any wake, sleep commands are refused (`reenter_ok_o`=0) until two things have happened: a `release_clr_i` strobe, and then three further `icyc_tick_i` pulses. `reenter_ok_o` rises on the edge of the third tick.
- R9: `wake_src_o` changes only on a deep-sleep exit or on an arm. Wake events that occur while awake leave it unchanged.
- R10: During and after `rst_n` low, the block is awake and not armed, `wake_src_o` is 0, and `reenter_ok_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| arm_set_i | input | 1 | Register write strobe that sets the arm bit |
| sleep_cmd_i | input | 1 | Sleep command strobe |
| icyc_tick_i | input | 1 | One pulse per instruction cycle |
| por_i | input | 1 | Power-on reset event |
| master_clr_n_i | input | 1 | Master clear, active low |
| ext_int_i | input | 1 | External interrupt pin, asynchronous |
| ext_int_pol_i | input | 1 | Wake level of the external pin |
| ext_int_en_i | input | 1 | External pin wake enable |
| wdog_tmo_i | input | 1 | Deep-sleep watchdog time-out event |
| release_clr_i | input | 1 | Strobe that clears the release bit after a wake |
| dsleep_o | output | 1 | Deep sleep active |
| wake_src_o | output | 4 | Sticky wake sources: [0] power-on, [1] master clear, [2] external pin, [3] watchdog |
| armed_o | output | 1 | Arm bit status |
| reenter_ok_o | output | 1 | Re-entry into deep sleep permitted |

## Verification
A cycle table walks the arming path through three cases: a command inside the window, a command after the window has closed on a tick, and a command that coincides with the closing tick. These cases separate a correct window edge from one that is off by a cycle. Directed runs drive the external pin in four ways: toward its wake level, away from it, held at the wake level from entry, and with the enable raised only after entry. Together they separate edge detection from level detection and from an enable that is not latched at entry. The other runs count the refused commands and ticks around the release clear, and fire several wake sources at once, which shows that the recording is sticky and that the guard length is exact.

// File: rtl/dsleep_pkg.sv
package dsleep_pkg;

  localparam int NUM_WAKE  = 4;
  localparam int WK_POR    = 0;
  localparam int WK_MCLR   = 1;
  localparam int WK_EXTINT = 2;
  localparam int WK_WDOG   = 3;

  typedef logic [NUM_WAKE-1:0] wake_vec_t;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_ARMED = 2'd1,
    ST_DEEP  = 2'd2
  } ds_state_e;

endpackage

// File: rtl/dsleep_pin_sync.sv
module dsleep_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o
);

  localparam int FILL_W = STAGES + 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic [FILL_W-1:0] fill_q;
  logic              lvl;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign lvl = chain_q[STAGES-1];

  // prev and fill: fill masks the false transitions out of the reset value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      fill_q <= '0;
    end else begin
      prev_q <= lvl;
      fill_q <= {fill_q[FILL_W-2:0], 1'b1};
    end
  end

  assign edge_o = fill_q[FILL_W-1] && (lvl == pol_i) && (prev_q != pol_i);

  AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && $stable(pol_i)) |=> !edge_o); // R7

endmodule

// File: rtl/dsleep_reentry_guard.sv
module dsleep_reentry_guard #(
  parameter int GUARD_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_exit_i,
  input  logic release_clr_i,
  input  logic tick_i,
  output logic ready_o
);

  localparam int CW = $clog2(GUARD_TICKS + 1);

  logic          release_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b0;
      cnt_q     <= '0;
    end else if (wake_exit_i) begin
      release_q <= 1'b1;
      cnt_q     <= '0;
    end else if (release_clr_i && release_q) begin
      release_q <= 1'b0;
      cnt_q     <= CW'(GUARD_TICKS);
    end else if (!release_q && (cnt_q != '0) && tick_i) begin
      cnt_q     <= cnt_q - 1'b1;
    end
  end

  assign ready_o = !release_q && (cnt_q == '0);

  AST_GUARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (release_clr_i && !tick_i && !wake_exit_i && !ready_o) |=> !ready_o); // R8

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(tick_i)); // R8

  AST_WAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_exit_i |=> !ready_o); // R8

endmodule

// File: rtl/dsleep_arm_ctrl.sv
module dsleep_arm_ctrl
  import dsleep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm_set_i,
  input  logic      sleep_cmd_i,
  input  logic      tick_i,
  input  logic      reenter_ok_i,
  input  logic      int_en_i,
  input  wake_vec_t wake_req_i,
  output logic      armed_o,
  output logic      dsleep_o,
  output logic      wake_exit_o,
  output wake_vec_t wake_src_o
);

  ds_state_e state_q;
  wake_vec_t src_q;
  wake_vec_t gated;
  logic      int_en_q;

  always_comb begin
    gated            = wake_req_i;
    gated[WK_EXTINT] = wake_req_i[WK_EXTINT] & int_en_q;
  end

  assign wake_exit_o = (state_q == ST_DEEP) && (|gated);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_AWAKE;
      src_q    <= '0;
      int_en_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_AWAKE: begin
          if (arm_set_i) begin
            state_q <= ST_ARMED;
            src_q   <= '0;
          end
        end
        ST_ARMED: begin
          if (arm_set_i) begin
            src_q <= '0;
          end else if (sleep_cmd_i && reenter_ok_i) begin
            state_q  <= ST_DEEP;
            int_en_q <= int_en_i;
          end else if (tick_i) begin
            state_q <= ST_AWAKE;
          end
        end
        ST_DEEP: begin
          if (|gated) begin
            state_q <= ST_AWAKE;
            src_q   <= src_q | gated;
          end
        end
        default: state_q <= ST_AWAKE;
      endcase
    end
  end

  assign armed_o    = (state_q == ST_ARMED) || (state_q == ST_DEEP);
  assign dsleep_o   = (state_q == ST_DEEP);
  assign wake_src_o = src_q;

  AST_ENTRY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsleep_o) |-> $past(armed_o && sleep_cmd_i && reenter_ok_i && !arm_set_i)); // R1

  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !dsleep_o && tick_i && !sleep_cmd_i && !arm_set_i) |=> !armed_o); // R2

  AST_EXIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsleep_o) |-> !armed_o); // R3

  AST_ARM_CLEARS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_set_i && !dsleep_o) |=> (armed_o && (wake_src_o == '0))); // R4

  AST_EXIT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsleep_o) |-> (wake_src_o != '0)); // R5

  AST_INT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_src_o[WK_EXTINT]) |-> $past(int_en_q)); // R6

  AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsleep_o && !arm_set_i) |=> $stable(wake_src_o)); // R9

endmodule

// File: rtl/dsleep_ctrl.sv
module dsleep_ctrl
  import dsleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_TICKS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_set_i,
  input  logic                sleep_cmd_i,
  input  logic                icyc_tick_i,
  input  logic                por_i,
  input  logic                master_clr_n_i,
  input  logic                ext_int_i,
  input  logic                ext_int_pol_i,
  input  logic                ext_int_en_i,
  input  logic                wdog_tmo_i,
  input  logic                release_clr_i,
  output logic                dsleep_o,
  output logic [NUM_WAKE-1:0] wake_src_o,
  output logic                armed_o,
  output logic                reenter_ok_o
);

  logic      int_edge;
  logic      wake_exit;
  wake_vec_t wake_req;

  dsleep_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_int_i),
    .pol_i  (ext_int_pol_i),
    .edge_o (int_edge)
  );

  always_comb begin
    wake_req            = '0;
    wake_req[WK_POR]    = por_i;
    wake_req[WK_MCLR]   = ~master_clr_n_i;
    wake_req[WK_EXTINT] = int_edge;
    wake_req[WK_WDOG]   = wdog_tmo_i;
  end

  dsleep_arm_ctrl u_arm_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_set_i    (arm_set_i),
    .sleep_cmd_i  (sleep_cmd_i),
    .tick_i       (icyc_tick_i),
    .reenter_ok_i (reenter_ok_o),
    .int_en_i     (ext_int_en_i),
    .wake_req_i   (wake_req),
    .armed_o      (armed_o),
    .dsleep_o     (dsleep_o),
    .wake_exit_o  (wake_exit),
    .wake_src_o   (wake_src_o)
  );

  dsleep_reentry_guard #(.GUARD_TICKS(GUARD_TICKS)) u_guard (
    .clk           (clk),
    .rst_n         (rst_n),
    .wake_exit_i   (wake_exit),
    .release_clr_i (release_clr_i),
    .tick_i        (icyc_tick_i),
    .ready_o       (reenter_ok_o)
  );

  AST_WDOG_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (dsleep_o && wdog_tmo_i) |=> (!dsleep_o && wake_src_o[WK_WDOG])); // R5

  AST_AWAKE_OK_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsleep_o) |=> !reenter_ok_o || release_clr_i); // R8

endmodule

// File: tb/test_dsleep_ctrl.sv
module test_dsleep_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_set = 1'b0, sleep_cmd = 1'b0, tick = 1'b0, por = 1'b0;
  logic       mclr_n = 1'b1, pin = 1'b0, pol = 1'b1, int_en = 1'b0;
  logic       wdog = 1'b0, rclr = 1'b0;
  logic       dsleep, armed, ok;
  logic [3:0] src;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dsleep_ctrl i_dsleep_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_set_i(arm_set), .sleep_cmd_i(sleep_cmd),
    .icyc_tick_i(tick), .por_i(por), .master_clr_n_i(mclr_n), .ext_int_i(pin),
    .ext_int_pol_i(pol), .ext_int_en_i(int_en), .wdog_tmo_i(wdog),
    .release_clr_i(rclr), .dsleep_o(dsleep), .wake_src_o(src), .armed_o(armed),
    .reenter_ok_o(ok)
  );

  // stim [15:9] = {arm, cmd, tick, por, mclr_low, wdog, rclr}
  // exp  [8:2]  = {dsleep, armed, src[3:0], reenter_ok}
  localparam logic [15:0] VEC [0:15] = '{
    {7'b1000000, 7'b0100001, 2'b00},  // R4 arm
    {7'b0100000, 7'b1100001, 2'b00},  // R1 enter
    {7'b0000000, 7'b1100001, 2'b00},  // R3 armed while deep
    {7'b0000010, 7'b0010000, 2'b00},  // R5 watchdog wake, R3 disarm
    {7'b0110000, 7'b0010000, 2'b00},  // R2 command while not armed
    {7'b0000001, 7'b0010000, 2'b00},  // R8 release clear
    {7'b0010000, 7'b0010000, 2'b00},  // R8 tick 1
    {7'b0010000, 7'b0010000, 2'b00},  // R8 tick 2
    {7'b0010000, 7'b0010001, 2'b00},  // R8 tick 3, ready
    {7'b1000000, 7'b0100001, 2'b00},  // R4 arm clears source
    {7'b0010000, 7'b0000001, 2'b00},  // R2 window closes
    {7'b0100000, 7'b0000001, 2'b00},  // R2 late command ignored
    {7'b1000000, 7'b0100001, 2'b00},  // R4 rearm
    {7'b0110000, 7'b1100001, 2'b00},  // R2 command on closing tick
    {7'b0001100, 7'b0000110, 2'b00},  // R5 por + master clear together
    {7'b0001000, 7'b0000110, 2'b00}   // R9 event while awake ignored
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {dsleep, armed, src, ok};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (ds,armed,src,ok)", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; arm_set = 0; sleep_cmd = 0; tick = 0; por = 0;
    mclr_n = 1; wdog = 0; rclr = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
  endtask

  task automatic p_arm();   arm_set = 1;   cyc(1); arm_set = 0;   endtask
  task automatic p_cmd();   sleep_cmd = 1; cyc(1); sleep_cmd = 0; endtask
  task automatic p_tick();  tick = 1;      cyc(1); tick = 0;      endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(2);
    chk("R10 in reset", 7'b0000001);
    rst_n = 1'b1;
    cyc(4);
    chk("R10 after reset", 7'b0000001);

    for (int i = 0; i < 16; i++) begin
      {arm_set, sleep_cmd, tick, por} = VEC[i][15:12];
      mclr_n = ~VEC[i][11];
      wdog   = VEC[i][10];
      rclr   = VEC[i][9];
      cyc(1);
      chk($sformatf("table row %0d", i), VEC[i][8:2]);
    end
    {arm_set, sleep_cmd, tick, por, wdog, rclr} = '0;
    mclr_n = 1;

    // R1: command together with arm write does not enter
    pin = 0; pol = 1; int_en = 1;
    do_reset();
    arm_set = 1; sleep_cmd = 1; cyc(1); arm_set = 0; sleep_cmd = 0;
    chk("R1 cmd with arm", 7'b0100001);
    p_cmd();
    chk("R1 enter", 7'b1100001);

    // R7: rising pin, exit after three edges
    pin = 1;
    cyc(2);
    chk("R7 sync latency", 7'b1100001);
    cyc(1);
    chk("R7 pin wake", 7'b0001000);

    // R8: guard counts ticks after release clear
    rclr = 1; cyc(1); rclr = 0;
    p_tick(); p_tick();
    p_arm(); p_cmd();
    chk("R8 blocked", 7'b0100000);
    p_tick();
    chk("R8 ready on third tick", 7'b0000001);
    p_arm(); p_cmd();
    chk("R8 reentry", 7'b1100001);

    // R7: level present at entry, wrong direction, then a true change
    cyc(5);
    chk("R7 level at entry", 7'b1100001);
    pin = 0; cyc(5);
    chk("R7 wrong direction", 7'b1100001);
    pin = 1; cyc(3);
    chk("R7 change to level", 7'b0001000);

    // R6: enable raised only after entry
    pin = 0; pol = 1; int_en = 0;
    do_reset();
    p_arm(); p_cmd();
    int_en = 1; pin = 1; cyc(5);
    chk("R6 enable not latched", 7'b1100001);
    wdog = 1; cyc(1); wdog = 0;
    chk("R6 only watchdog bit", 7'b0010000);

    // R7: low wake level
    pin = 1; pol = 0; int_en = 1;
    do_reset();
    p_arm(); p_cmd();
    pin = 0; cyc(3);
    chk("R7 falling wake", 7'b0001000);

    // R9: events while awake
    do_reset();
    wdog = 1; por = 1; mclr_n = 0; cyc(1);
    wdog = 0; por = 0; mclr_n = 1; cyc(1);
    chk("R9 awake events ignored", 7'b0000001);

    // R5: three sources together
    pin = 0; pol = 1; int_en = 1;
    do_reset();
    p_arm(); p_cmd();
    por = 1; mclr_n = 0; wdog = 1; cyc(1);
    por = 0; mclr_n = 1; wdog = 0;
    chk("R5 simultaneous sources", 7'b0010110);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule